// File: doc/BRIEF.md
# Video output rounding and formatting unit

This block sits after the arithmetic of a video filter. It takes the wide signed result and turns it into the 16-bit word that leaves the chip. The block moves the effective least significant bit to the chosen position and rounds it there by adding half a unit. It saturates on overflow instead of wrapping. It codes the word as two's complement, inverted offset binary or offset binary. In the studio video modes it also keeps results away from the codes reserved for timing references.

The raw result is `IN_W = OUT_W + HEAD_W + FRAC_W` bits wide, 22 bits with the defaults. Its least significant bit is 1/16 of the least significant bit of the 16-bit output word. Its top two bits are headroom above the output range. Each result is registered once, when the upstream valid strobe is high. The registered word is also driven onto a bus that an asynchronous active-low enable can release.

Top module: `vid_out_fmt`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dout` becomes 0x0000, whatever the other inputs are.
- R2: On an edge where `vld_in` is high, `dout` takes the formatted value of `res_in` and of the control inputs, one cycle of latency. On an edge where `vld_in` is low, `dout` keeps its value.
- R3: Outside video mode, `rnd_sel` sets the kept width K: K = 16 - `rnd_sel` for values 0..6, and K = 8 for value 7. The top K bits carry the result. A one is added at the position just below the kept LSB, with the raw LSB weighted 1/16 of output bit 0. The 16-K bits below the kept LSB are then zero before coding.
- R4: After rounding, the value saturates to the signed K-bit range [-2^(K-1), 2^(K-1)-1]. It does not wrap. This applies even when rounding itself carries the value out of range.
- R5: Coding outside video mode. With `tco`=1, the word is two's complement. With `tco`=0 and `uns_en`=0, bits 14..0 are inverted and bit 15 is unchanged (inverted offset binary). With `tco`=0 and `uns_en`=1, only bit 15 is inverted (offset binary).
- R6: When `uns_en`=1, `tco`=1, `vid_en`=0 and `rnd_sel` is not 0, a negative result gives 0, so bit 15 of `dout` is always 0 (15-bit limit).
- R7: When `vid_en`=1, `tco`, `uns_en` and `rnd_sel[2:1]` have no effect. `rnd_sel[0]`=0 selects a 10-bit code and 1 selects an 8-bit code. The code is offset binary in the top bits of `dout`, and the bits below it are 0.
- R8: In video mode the codes reserved for timing references never appear. 10-bit codes are clamped to 0x004..0x3FB and 8-bit codes to 0x01..0xFE.
- R9: While `oe_n` is low, `dout_bus` equals `dout`. While `oe_n` is high, `dout_bus` is high impedance. `oe_n` has no effect on the registered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| vld_in | input | 1 | Result valid strobe; loads the output register |
| res_in | input | 22 | Signed raw result from the filter arithmetic |
| rnd_sel | input | 3 | Kept-width select (bit 0 picks 10 or 8 bits in video mode) |
| tco | input | 1 | 1 = two's complement output, 0 = inverted or offset coding |
| uns_en | input | 1 | Unsigned (offset binary) output coding enable |
| vid_en | input | 1 | Studio video code mode enable |
| oe_n | input | 1 | Asynchronous output enable for the bus, active low |
| dout | output | 16 | Registered formatted word |
| dout_bus | output | 16 | Tri-state copy of `dout` |

## Verification
The assertions assume that the control inputs are stable across the clock edge at which `vld_in` loads a result. Each property names the inputs of the loading edge and checks `dout` one edge later. The bench changes every input on the falling edge only, so each loading edge sees a settled set of controls. For the same reason the bus property samples `oe_n` at the rising edge, and the bench never toggles it near one. The random phase spreads raw values over the whole 22-bit range, including the headroom extremes, so the saturation limits and the reserved-code limits are reached in every kept width.

// File: rtl/vof_pkg.sv
// Shared types of the video output formatting unit.
package vof_pkg;
    // Output coding applied as the last step before the register.
    typedef enum logic [1:0] {
        CODE_TWOS   = 2'd0,
        CODE_INVOFF = 2'd1,
        CODE_OFFSET = 2'd2
    } code_e;
endpackage

// File: rtl/vof_round.sv
// Half-LSB rounding at a movable position.
// Adds a one just below the kept LSB, then shifts the discarded bits out.
// Assumes FRAC_W >= 1 and drop <= OUT_W.
module vof_round #(
    parameter int OUT_W  = 16,
    parameter int HEAD_W = 2,
    parameter int FRAC_W = 4,
    localparam int IN_W   = OUT_W + HEAD_W + FRAC_W,
    localparam int DROP_W = $clog2(OUT_W + 1)
) (
    input  logic signed [IN_W-1:0] res,
    input  logic [DROP_W-1:0]      drop,
    output logic signed [IN_W:0]   q
);
    localparam logic signed [IN_W:0] ONE = (IN_W+1)'(1);

    logic signed [IN_W:0] ext;
    logic signed [IN_W:0] half;
    logic signed [IN_W:0] sum;
    int                   sh;

    // Sign-extend, add the rounding one, shift to units of the kept LSB.
    always_comb begin
        sh   = FRAC_W + int'(drop);
        ext  = {res[IN_W-1], res};
        half = ONE <<< (sh - 1);
        sum  = ext + half;
        q    = sum >>> sh;
    end
endmodule

// File: rtl/vof_limit.sv
// Saturating limiter and alignment.
// Clamps the rounded value to the signed range of the kept width, shrunk by
// a guard margin at both ends (reserved video codes). The low bound is raised
// to zero for the 15-bit limit. Shifts the result back to the MSB end.
// Assumes keep = OUT_W - drop >= 2 and margin < 2^(keep-1).
module vof_limit #(
    parameter int OUT_W   = 16,
    parameter int HEAD_W  = 2,
    parameter int FRAC_W  = 4,
    parameter int GUARD_W = 3,
    localparam int IN_W   = OUT_W + HEAD_W + FRAC_W,
    localparam int DROP_W = $clog2(OUT_W + 1)
) (
    input  logic signed [IN_W:0] q,
    input  logic [DROP_W-1:0]    drop,
    input  logic [GUARD_W-1:0]   margin,
    input  logic                 lim15,
    output logic [OUT_W-1:0]     w
);
    localparam logic signed [IN_W:0] ONE = (IN_W+1)'(1);

    logic signed [IN_W:0] span;
    logic signed [IN_W:0] marg_x;
    logic signed [IN_W:0] lim_hi;
    logic signed [IN_W:0] lim_lo;
    logic [OUT_W-1:0]     v;
    int                   keep;

    // Derive the limits that belong to the kept width and the mode.
    always_comb begin
        keep   = OUT_W - int'(drop);
        span   = ONE <<< (keep - 1);
        marg_x = (IN_W+1)'(margin);
        lim_hi = span - ONE - marg_x;
        lim_lo = lim15 ? '0 : marg_x - span;
    end

    // Clamp the value, then place it in the top bits with zeros below.
    always_comb begin
        if (q > lim_hi) begin
            v = lim_hi[OUT_W-1:0];
        end else if (q < lim_lo) begin
            v = lim_lo[OUT_W-1:0];
        end else begin
            v = q[OUT_W-1:0];
        end
        w = v << drop;
    end
endmodule

// File: rtl/vof_code.sv
// Output coder: two's complement, inverted offset binary or offset binary.
// Assumes the input is an aligned two's complement word.
module vof_code
    import vof_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic [OUT_W-1:0] w,
    input  code_e            sel,
    output logic [OUT_W-1:0] coded
);
    localparam logic [OUT_W-1:0] LOW_MASK = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] TOP_MASK = {1'b1, {(OUT_W-1){1'b0}}};

    // Flip the bits that the selected coding requires.
    always_comb begin
        unique case (sel)
            CODE_INVOFF: coded = w ^ LOW_MASK;
            CODE_OFFSET: coded = w ^ TOP_MASK;
            default:     coded = w;
        endcase
    end
endmodule

// File: rtl/vid_out_fmt.sv
// Video output rounding and formatting unit (top).
// Decodes the controls into kept width, guard margin, limit and coding.
// Chains round -> limit -> code and registers the word on vld_in.
// Assumes the controls are stable at the loading edge. oe_n is asynchronous.
module vid_out_fmt
    import vof_pkg::*;
#(
    parameter int OUT_W    = 16,
    parameter int HEAD_W   = 2,
    parameter int FRAC_W   = 4,
    parameter int WIDE_W   = 10,
    parameter int NARROW_W = 8,
    parameter int WIDE_GUARD   = 4,
    parameter int NARROW_GUARD = 1,
    parameter int GUARD_W  = 3,
    localparam int IN_W    = OUT_W + HEAD_W + FRAC_W,
    localparam int DROP_W  = $clog2(OUT_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_in,
    input  logic [IN_W-1:0]      res_in,
    input  logic [2:0]           rnd_sel,
    input  logic                 tco,
    input  logic                 uns_en,
    input  logic                 vid_en,
    input  logic                 oe_n,
    output logic [OUT_W-1:0]     dout,
    output logic [OUT_W-1:0]     dout_bus
);
    logic [DROP_W-1:0]    drop;
    logic [GUARD_W-1:0]   margin;
    logic                 lim15;
    code_e                code_sel;
    logic signed [IN_W:0] q_rnd;
    logic [OUT_W-1:0]     w_lim;
    logic [OUT_W-1:0]     w_code;

    // Map the controls to dropped bit count and guard margin.
    always_comb begin
        if (vid_en) begin
            drop   = rnd_sel[0] ? DROP_W'(OUT_W - NARROW_W) : DROP_W'(OUT_W - WIDE_W);
            margin = rnd_sel[0] ? GUARD_W'(NARROW_GUARD) : GUARD_W'(WIDE_GUARD);
        end else begin
            drop   = (rnd_sel == 3'b111) ? DROP_W'(OUT_W - NARROW_W) : DROP_W'(rnd_sel);
            margin = '0;
        end
    end

    // Choose the 15-bit limit and the output coding.
    always_comb begin
        lim15 = !vid_en && uns_en && tco && (rnd_sel != 3'b000);
        if (vid_en || (uns_en && !tco)) begin
            code_sel = CODE_OFFSET;
        end else if (!tco) begin
            code_sel = CODE_INVOFF;
        end else begin
            code_sel = CODE_TWOS;
        end
    end

    vof_round #(.OUT_W(OUT_W), .HEAD_W(HEAD_W), .FRAC_W(FRAC_W)) u_round (
        .res  (res_in),
        .drop (drop),
        .q    (q_rnd)
    );

    vof_limit #(.OUT_W(OUT_W), .HEAD_W(HEAD_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) u_limit (
        .q      (q_rnd),
        .drop   (drop),
        .margin (margin),
        .lim15  (lim15),
        .w      (w_lim)
    );

    vof_code #(.OUT_W(OUT_W)) u_code (
        .w     (w_lim),
        .sel   (code_sel),
        .coded (w_code)
    );

    // Output register: one cycle of latency, loads only on the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (vld_in) begin
            dout <= w_code;
        end
    end

    // Release the bus while the enable is high.
    assign dout_bus = oe_n ? {OUT_W{1'bz}} : dout;
endmodule

// File: rtl/vid_out_fmt_chk.sv
// Property checker for vid_out_fmt, attached by bind.
// Assumes the controls seen at a loading edge are the ones that produced dout.
module vid_out_fmt_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vld_in,
    input logic [2:0]       rnd_sel,
    input logic             tco,
    input logic             uns_en,
    input logic             vid_en,
    input logic             oe_n,
    input logic [OUT_W-1:0] dout,
    input logic [OUT_W-1:0] dout_bus
);
    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_in |=> $stable(dout));

    // R3
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && tco && !vid_en && rnd_sel == 3'b111) |=> (dout[OUT_W-9:0] == '0));

    // R6
    limit15_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && !vid_en && uns_en && tco && rnd_sel != 3'b000) |=> !dout[OUT_W-1]);

    // R8
    narrow_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && vid_en && rnd_sel[0]) |=>
        (dout[OUT_W-1 -: 8] != 8'h00 && dout[OUT_W-1 -: 8] != 8'hFF && dout[OUT_W-9:0] == '0));

    // R8
    wide_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && vid_en && !rnd_sel[0]) |=>
        (dout[OUT_W-1 -: 10] >= 10'h004 && dout[OUT_W-1 -: 10] <= 10'h3FB && dout[OUT_W-11:0] == '0));

    // R9
    bus_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (dout_bus == dout));
endmodule

bind vid_out_fmt vid_out_fmt_chk #(.OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_in   (vld_in),
    .rnd_sel  (rnd_sel),
    .tco      (tco),
    .uns_en   (uns_en),
    .vid_en   (vid_en),
    .oe_n     (oe_n),
    .dout     (dout),
    .dout_bus (dout_bus)
);

// File: tb/sim_vid_out_fmt.sv
`timescale 1ns/1ps
// Bench for vid_out_fmt: behavioural reference model, compared every cycle.
module sim_vid_out_fmt;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               vld_in = 1'b0;
    logic signed [21:0] res_in = '0;
    logic [2:0]         rnd_sel = '0;
    logic               tco = 1'b1;
    logic               uns_en = 1'b0;
    logic               vid_en = 1'b0;
    logic               oe_n = 1'b0;
    logic [15:0]        dout;
    logic [15:0]        dout_bus;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [15:0] exp_w = '0;

    always #4 clk = ~clk;

    vid_out_fmt u0 (
        .clk(clk), .rst_n(rst_n), .vld_in(vld_in), .res_in(res_in),
        .rnd_sel(rnd_sel), .tco(tco), .uns_en(uns_en), .vid_en(vid_en),
        .oe_n(oe_n), .dout(dout), .dout_bus(dout_bus)
    );

    // Reference: arithmetic on integers, straight from the requirements.
    function automatic logic [15:0] ref_word(longint r, int rnd, bit t, bit u, bit v);
        int     keep;
        int     m;
        longint sh, q, hi, lo;
        logic [15:0] w;
        if (v) begin
            keep = (rnd % 2 == 1) ? 8 : 10;
            m    = (rnd % 2 == 1) ? 1 : 4;
        end else begin
            keep = (rnd == 7) ? 8 : 16 - rnd;
            m    = 0;
        end
        sh = 4 + 16 - keep;
        q  = (r + (longint'(1) <<< (sh - 1))) >>> sh;
        hi = (longint'(1) <<< (keep - 1)) - 1 - m;
        lo = m - (longint'(1) <<< (keep - 1));
        if (!v && u && t && rnd != 0) lo = 0;
        if (q > hi) q = hi;
        if (q < lo) q = lo;
        w = 16'(q <<< (16 - keep));
        if (v || (u && !t)) w = w ^ 16'h8000;
        else if (!u && !t) w = w ^ 16'h7FFF;
        return w;
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one set of inputs at a falling edge, compare at the next one.
    task automatic step(input logic signed [21:0] r, input logic [2:0] rs,
                        input logic t, input logic u, input logic v,
                        input logic vl, input logic oe, input string tag);
        res_in = r; rnd_sel = rs; tco = t; uns_en = u; vid_en = v;
        vld_in = vl; oe_n = oe;
        if (vl) exp_w = ref_word(longint'(r), int'(rs), t, u, v);
        @(negedge clk);
        check(dout, exp_w, tag);
        if (!oe) check(dout_bus, exp_w, {tag, " bus R9"});
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        res_in = 22'sh155555; vld_in = 1'b1; rnd_sel = 3'd0;
        repeat (3) @(negedge clk);
        check(dout, 16'h0000, "R1 reset value");
        rst_n = 1'b1;
        // R3 basic rounding, full width: 291/16 -> 18
        step(22'sd291, 3'd0, 1, 0, 0, 1, 0, "R3 round 16-bit");
        step(-22'sd24, 3'd0, 1, 0, 0, 1, 0, "R3 round negative half");
        step(22'sd5000, 3'd7, 1, 0, 0, 1, 0, "R3 8-bit keep");
        step(22'sd5000, 3'd3, 1, 0, 0, 1, 0, "R3 13-bit keep");
        // R4 saturation, including carry out of range by rounding
        step(22'sh1FFFFF, 3'd0, 1, 0, 0, 1, 0, "R4 sat positive");
        step(-22'sh200000, 3'd0, 1, 0, 0, 1, 0, "R4 sat negative");
        step(22'sd524280, 3'd0, 1, 0, 0, 1, 0, "R4 carry into sat");
        step(22'sh1FFFFF, 3'd5, 1, 0, 0, 1, 0, "R4 sat 11-bit");
        // R5 codings
        step(22'sd1600, 3'd0, 0, 0, 0, 1, 0, "R5 inverted offset");
        step(-22'sd1600, 3'd0, 0, 1, 0, 1, 0, "R5 offset binary");
        step(-22'sd1600, 3'd0, 1, 1, 0, 1, 0, "R5 signed rnd0 no limit");
        // R6 15-bit limit
        step(-22'sd1600, 3'd2, 1, 1, 0, 1, 0, "R6 negative to zero");
        step(22'sh1FFFFF, 3'd1, 1, 1, 0, 1, 0, "R6 positive limit");
        // R7 video mode ignores tco/uns and rnd_sel[2:1]
        step(22'sd100000, 3'd0, 1, 0, 1, 1, 0, "R7 10-bit code");
        step(22'sd100000, 3'd6, 0, 1, 1, 1, 0, "R7 10-bit ignores controls");
        step(22'sd100000, 3'd1, 0, 0, 1, 1, 0, "R7 8-bit code");
        // R8 reserved codes
        step(-22'sh200000, 3'd0, 1, 0, 1, 1, 0, "R8 10-bit low clamp");
        step(22'sh1FFFFF, 3'd0, 1, 0, 1, 1, 0, "R8 10-bit high clamp");
        step(-22'sh200000, 3'd1, 1, 0, 1, 1, 0, "R8 8-bit low clamp");
        step(22'sh1FFFFF, 3'd1, 1, 0, 1, 1, 0, "R8 8-bit high clamp");
        // R2 hold while idle
        step(22'sd777, 3'd0, 1, 0, 0, 0, 0, "R2 hold idle");
        step(-22'sd12345, 3'd4, 0, 1, 0, 0, 0, "R2 hold idle 2");
        // R9 bus released; register untouched, then bus follows again
        step(22'sd31, 3'd0, 1, 0, 0, 0, 1, "R9 oe high hold");
        step(22'sd31, 3'd0, 1, 0, 0, 1, 1, "R9 oe high load");
        step(22'sd31, 3'd0, 1, 0, 0, 0, 0, "R9 oe low again");
        // Random phase over all modes
        for (int i = 0; i < 4000; i++) begin
            logic signed [21:0] r;
            logic [2:0] rs;
            logic t, u, v, vl;
            string tag;
            r  = 22'($urandom);
            if (i % 9 == 0) r = (i % 2 == 0) ? 22'sh1FFFFF : -22'sh200000;
            rs = 3'($urandom_range(0, 7));
            t  = 1'($urandom); u = 1'($urandom);
            v  = ($urandom_range(0, 3) == 0);
            vl = ($urandom_range(0, 3) != 0);
            if (!vl) tag = "R2 random hold";
            else if (v) tag = "R7/R8 random video";
            else if (u && t && rs != 0) tag = "R6 random limit";
            else tag = "R3/R4/R5 random";
            step(r, rs, t, u, v, vl, 0, tag);
        end
        // R1 reset again mid-run
        rst_n = 1'b0; vld_in = 1'b1;
        @(negedge clk);
        exp_w = '0;
        check(dout, 16'h0000, "R1 reset mid-run");
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule